// File: doc/BRIEF.md
# Bit-Serial Shift and Rotate Unit with Ones Weight

This unit sits in the execute stage of a small 16-bit processor. It shifts or rotates one operand by a signed amount and moves one bit position per clock. A caller raises `start_i` for one cycle while the unit is idle and presents the operand, an operation code, a shift descriptor, the descriptor's source and the current extend flag. Some cycles later the unit pulses `done_o`. From that cycle on, `result_o`, `carry_o` and `x_o` hold the outcome until the next accepted start.

The descriptor is a signed count. A negative count reverses the direction that the operation code names, so a single operation can move bits either way. Four kinds of movement are provided: logical, arithmetic, plain rotate, and rotate through the extend bit.

When the descriptor comes from a register, the caller may ask for the weight instead of the data. The shift then runs exactly as specified, and the unit returns how many one bits it pushed out of the operand. For right-going shifts this counts the bits leaving the least-significant end; for left-going shifts it counts the bits leaving the most-significant end.

Top module: `shift_weight_unit`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `carry_o` and `x_o` are 0 and `result_o` is 0.
- R2: The shift amount is the two's-complement value of `desc_i[4:0]`, in the range -16 to 15, and `desc_i[15:5]` is ignored. `op_i[2]` names the direction (0 = left, 1 = right). A negative amount moves the other way by its magnitude.
- R3: Kind code `op_i[1:0]=00` is a logical shift: vacated positions fill with 0.
- R4: Kind code `01` is an arithmetic shift: a right shift copies bit 15 into the vacated position, and a left shift fills with 0.
- R5: Kind code `10` is a rotate: the bit leaving one end re-enters at the other.
- R6: Kind code `11` rotates through the extend bit: the 16 operand bits and `x_i` form a 17-bit ring, and the bit leaving the operand goes into the extend bit while the old extend bit enters the vacated position.
- R7: After a non-zero amount, `carry_o` and `x_o` both equal the last bit shifted out. After a zero amount, the operand is unchanged, `carry_o` is 0 and `x_o` equals `x_i`.
- R8: A start is taken only while `busy_o` is 0. For an amount of magnitude N, `done_o` is a one-cycle pulse that is high after N+1 rising edges, counting the edge that takes the start. `busy_o` is high in between, and `done_o` never coincides with `busy_o`.
- R9: With `weight_i=1` and `desc_is_reg_i=1`, `result_o` is the number of one bits shifted out, zero-extended. Right-going shifts count bits leaving bit 0; left-going shifts count bits leaving bit 15. `carry_o` and `x_o` behave as in R7.
- R10: With `weight_i=1` and `desc_is_reg_i=0`, the weight request has no effect and `result_o` is the shifted data.
- R11: `start_i` raised while `busy_o` is 1 is ignored. While idle with no start, `result_o`, `carry_o` and `x_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin an operation |
| op_i | input | 3 | Bit 2 direction (0 left, 1 right); bits 1:0 kind |
| desc_i | input | 16 | Shift descriptor; low 5 bits are the signed amount |
| desc_is_reg_i | input | 1 | 1 when the descriptor came from a register |
| weight_i | input | 1 | Request for the ones count instead of data |
| x_i | input | 1 | Current extend flag |
| operand_i | input | 16 | Value to shift |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 16 | Shifted data or ones count |
| carry_o | output | 1 | Last bit shifted out |
| x_o | output | 1 | Updated extend flag |

## Verification
Directed operands are chosen so that each kind gives a different answer from the others. A negative operand under an arithmetic right shift separates sign fill from zero fill. A rotate of magnitude 16 must return the operand unchanged, while a rotate through extend of 15 depends on the incoming extend bit. Descriptors with the upper bits set and negative low fields show whether only five bits are decoded and whether the direction flips. Random operands, codes and descriptors, with weight requests from both descriptor sources, check the ones count against the data result and the cycle count against the magnitude.

// File: rtl/sw_pkg.sv
package sw_pkg;

    typedef enum logic [1:0] {
        KIND_LOGIC = 2'b00,
        KIND_ARITH = 2'b01,
        KIND_ROT   = 2'b10,
        KIND_ROTX  = 2'b11
    } shift_kind_e;

endpackage

// File: rtl/sw_desc_decode.sv
module sw_desc_decode #(
    parameter int AMT_W = 5,
    parameter int CNT_W = AMT_W
) (
    input  logic [AMT_W-1:0] amt_i,
    input  logic             right_i,
    output logic             right_o,
    output logic [CNT_W-1:0] count_o
);
    logic             negative;
    logic [AMT_W-1:0] magnitude;

    always_comb begin
        negative  = amt_i[AMT_W-1];
        magnitude = negative ? (~amt_i + AMT_W'(1)) : amt_i;
        right_o   = right_i ^ negative;
        count_o   = CNT_W'(magnitude);
    end
endmodule

// File: rtl/sw_step.sv
module sw_step
    import sw_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic             x_i,
    input  shift_kind_e      kind_i,
    input  logic             right_i,
    output logic [WIDTH-1:0] data_o,
    output logic             out_bit_o
);
    logic fill;

    always_comb begin
        if (right_i) begin
            out_bit_o = data_i[0];
            case (kind_i)
                KIND_ARITH: fill = data_i[WIDTH-1];
                KIND_ROT:   fill = data_i[0];
                KIND_ROTX:  fill = x_i;
                default:    fill = 1'b0;
            endcase
            data_o = {fill, data_i[WIDTH-1:1]};
        end else begin
            out_bit_o = data_i[WIDTH-1];
            case (kind_i)
                KIND_ROT:   fill = data_i[WIDTH-1];
                KIND_ROTX:  fill = x_i;
                default:    fill = 1'b0;
            endcase
            data_o = {data_i[WIDTH-2:0], fill};
        end
    end
endmodule

// File: rtl/shift_weight_unit.sv
module shift_weight_unit
    import sw_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       op_i,
    input  logic [WIDTH-1:0] desc_i,
    input  logic             desc_is_reg_i,
    input  logic             weight_i,
    input  logic             x_i,
    input  logic [WIDTH-1:0] operand_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             x_o
);
    localparam int AMT_W = $clog2(WIDTH) + 1;
    localparam int CNT_W = AMT_W;

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             right;
        shift_kind_e      kind;
        logic             wmode;
        logic [CNT_W-1:0] remain;
        logic [WIDTH-1:0] data;
        logic             xbit;
        logic             carry;
        logic [CNT_W-1:0] ones;
    } state_t;

    state_t st_d, st_q;

    logic             dec_right;
    logic [CNT_W-1:0] dec_count;
    logic [WIDTH-1:0] step_data;
    logic             step_out;
    logic             unused_desc_hi;

    assign unused_desc_hi = ^desc_i[WIDTH-1:AMT_W];

    sw_desc_decode #(
        .AMT_W (AMT_W),
        .CNT_W (CNT_W)
    ) dec_i (
        .amt_i   (desc_i[AMT_W-1:0]),
        .right_i (op_i[2]),
        .right_o (dec_right),
        .count_o (dec_count)
    );

    sw_step #(
        .WIDTH (WIDTH)
    ) step_i (
        .data_i    (st_q.data),
        .x_i       (st_q.xbit),
        .kind_i    (st_q.kind),
        .right_i   (st_q.right),
        .data_o    (step_data),
        .out_bit_o (step_out)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.kind   = shift_kind_e'(op_i[1:0]);
                st_d.right  = dec_right;
                st_d.wmode  = weight_i & desc_is_reg_i;
                st_d.data   = operand_i;
                st_d.ones   = '0;
                st_d.xbit   = x_i;
                st_d.carry  = 1'b0;
                st_d.remain = dec_count;
                if (dec_count == '0) begin
                    st_d.done = 1'b1;
                end else begin
                    st_d.busy = 1'b1;
                end
            end
        end else begin
            st_d.data   = step_data;
            st_d.xbit   = step_out;
            st_d.carry  = step_out;
            st_d.remain = st_q.remain - CNT_W'(1);
            if (step_out) begin
                st_d.ones = st_q.ones + CNT_W'(1);
            end
            if (st_q.remain == CNT_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = st_q.busy;
    assign done_o   = st_q.done;
    assign result_o = st_q.wmode ? WIDTH'(st_q.ones) : st_q.data;
    assign carry_o  = st_q.carry;
    assign x_o      = st_q.xbit;
endmodule

// File: rtl/sw_checker.sv
module sw_checker #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [WIDTH-1:0] desc_i,
    input logic             desc_is_reg_i,
    input logic             weight_i,
    input logic             x_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [WIDTH-1:0] result_o,
    input logic             carry_o,
    input logic             x_o
);
    localparam int AMT_W = $clog2(WIDTH) + 1;

    logic [AMT_W-1:0] amt;
    logic [AMT_W-1:0] mag;
    logic [AMT_W-1:0] pend_q;
    logic             wm_q;
    logic             accept;
    logic             unused_hi;

    assign unused_hi = ^desc_i[WIDTH-1:AMT_W];
    assign amt       = desc_i[AMT_W-1:0];
    assign mag       = amt[AMT_W-1] ? (AMT_W'(0) - amt) : amt;
    assign accept    = start_i && !busy_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            wm_q   <= 1'b0;
        end else if (accept) begin
            pend_q <= mag;
            wm_q   <= weight_i & desc_is_reg_i;
        end else if (busy_o) begin
            pend_q <= pend_q - AMT_W'(1);
        end
    end

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R8
    AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> pend_q == '0); // R8
    AST_BUSY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> pend_q != '0); // R8
    AST_WEIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && wm_q) |-> (result_o <= WIDTH)); // R9
    AST_ZERO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mag == '0) |=> (done_o && !carry_o && x_o == $past(x_i))); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(result_o) && $stable(carry_o) && $stable(x_o))); // R11
endmodule

bind shift_weight_unit sw_checker #(.WIDTH(WIDTH)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .desc_i        (desc_i),
    .desc_is_reg_i (desc_is_reg_i),
    .weight_i      (weight_i),
    .x_i           (x_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .result_o      (result_o),
    .carry_o       (carry_o),
    .x_o           (x_o)
);

// File: tb/shift_weight_unit_tb_top.sv
`timescale 1ns/1ps
module shift_weight_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [15:0] desc_i = '0;
    logic        desc_is_reg_i = 1'b0;
    logic        weight_i = 1'b0;
    logic        x_i = 1'b0;
    logic [15:0] operand_i = '0;
    logic        busy_o, done_o, carry_o, x_o;
    logic [15:0] result_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    shift_weight_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .desc_i(desc_i), .desc_is_reg_i(desc_is_reg_i), .weight_i(weight_i),
        .x_i(x_i), .operand_i(operand_i), .busy_o(busy_o), .done_o(done_o),
        .result_o(result_o), .carry_o(carry_o), .x_o(x_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void model(input logic [15:0] opnd, input logic [2:0] op,
                                  input logic [15:0] desc, input logic isreg,
                                  input logic wt, input logic xin,
                                  output logic [15:0] res, output logic c,
                                  output logic xo, output int edges);
        int          n;
        int          ones;
        logic        right;
        logic        b;
        logic [15:0] d;
        logic        xr;
        n = desc[4] ? int'(desc[4:0]) - 32 : int'(desc[4:0]);
        right = op[2];
        if (n < 0) begin
            right = !right;
            n = -n;
        end
        d = opnd; xr = xin; ones = 0; c = 1'b0; xo = xin;
        for (int i = 0; i < n; i++) begin
            b = right ? d[0] : d[15];
            case (op[1:0])
                2'b00: d = right ? (d >> 1) : (d << 1);
                2'b01: d = right ? 16'($signed(d) >>> 1) : (d << 1);
                2'b10: d = right ? ((d >> 1) | (d << 15)) : ((d << 1) | (d >> 15));
                default: begin
                    d = right ? ((d >> 1) | {xr, 15'b0}) : ((d << 1) | {15'b0, xr});
                    xr = b;
                end
            endcase
            ones += int'(b);
            c = b; xo = b;
        end
        res = (wt && isreg) ? 16'(ones) : d;
        edges = n + 1;
    endfunction

    task automatic run(input string req, input logic [15:0] opnd, input logic [2:0] op,
                       input logic [15:0] desc, input logic isreg, input logic wt,
                       input logic xin, input logic intrude);
        logic [15:0] er;
        logic        ec, ex;
        int          ee;
        int          edges;
        model(opnd, op, desc, isreg, wt, xin, er, ec, ex, ee);
        @(negedge clk);
        start_i = 1'b1; operand_i = opnd; op_i = op; desc_i = desc;
        desc_is_reg_i = isreg; weight_i = wt; x_i = xin;
        @(posedge clk);
        edges = 1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && edges < 40) begin
            if (intrude && edges == 3) begin
                start_i = 1'b1; operand_i = ~opnd; op_i = 3'b010; desc_i = 16'h0001;
                x_i = ~xin; weight_i = 1'b0;
            end
            @(posedge clk);
            edges++;
            @(negedge clk);
            start_i = 1'b0;
        end
        check(req, "result", int'(result_o), int'(er));
        check("R7", "carry", int'(carry_o), int'(ec));
        check("R7", "x", int'(x_o), int'(ex));
        check("R8", "edges", edges, ee);
        check("R8", "busy after done", int'(busy_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] held;
        void'($urandom(32'h5A17));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "busy", int'(busy_o), 0);
        check("R1", "done", int'(done_o), 0);
        check("R1", "result", int'(result_o), 0);
        check("R1", "carry", int'(carry_o), 0);
        check("R1", "x", int'(x_o), 0);
        rst_n = 1'b1;

        run("R7", 16'h8001, 3'b000, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0);
        run("R4", 16'h8421, 3'b101, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b0);
        run("R4", 16'hC001, 3'b001, 16'h0002, 1'b0, 1'b0, 1'b0, 1'b0);
        run("R2", 16'h1234, 3'b000, 16'hFFFD, 1'b1, 1'b0, 1'b0, 1'b0);
        run("R3", 16'hF00F, 3'b100, 16'h0007, 1'b1, 1'b0, 1'b0, 1'b0);
        run("R5", 16'hA5C3, 3'b110, 16'h0010, 1'b1, 1'b0, 1'b0, 1'b0);
        run("R5", 16'h8003, 3'b010, 16'h0003, 1'b0, 1'b0, 1'b0, 1'b0);
        run("R6", 16'h0F0F, 3'b011, 16'h000F, 1'b0, 1'b0, 1'b1, 1'b0);
        run("R6", 16'h0001, 3'b111, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0);
        run("R10", 16'hFF00, 3'b100, 16'h0008, 1'b0, 1'b1, 1'b0, 1'b0);
        run("R9", 16'hFFFF, 3'b100, 16'h000F, 1'b1, 1'b1, 1'b0, 1'b0);
        run("R9", 16'hC000, 3'b000, 16'hFFF0, 1'b1, 1'b1, 1'b0, 1'b0);
        run("R11", 16'h00F0, 3'b100, 16'h000F, 1'b1, 1'b0, 1'b0, 1'b1);

        held = result_o;
        repeat (4) @(negedge clk);
        check("R11", "idle hold", int'(result_o), int'(held));

        for (int k = 0; k < 300; k++) begin
            logic [2:0]  op;
            logic        isreg, wt;
            string       tag;
            op = 3'($urandom);
            isreg = 1'($urandom);
            wt = 1'($urandom);
            case (op[1:0])
                2'b00: tag = "R3";
                2'b01: tag = "R4";
                2'b10: tag = "R5";
                default: tag = "R6";
            endcase
            if (wt) tag = isreg ? "R9" : "R10";
            run(tag, 16'($urandom), op, 16'($urandom), isreg, wt, 1'($urandom), 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule